// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block walks the descriptor of a DMA transfer that has three nested dimensions: a run of contiguous bytes (the array), a count of arrays per frame, and a count of frames per block. For each synchronization event it accepts, it emits array requests. Each request carries a source byte address, a destination byte address and a byte length. Between requests it applies the signed strides held in the descriptor. A small descriptor store is written through a load port. Any write can also make the written descriptor the active one at once.

When the active descriptor is used up, the block pulses a final-completion flag together with the descriptor's 6-bit completion code. It then links to the descriptor named in its link field, or goes idle when that field holds the end-of-chain value. Events that cannot be served are dropped and reported on a missed-event pulse. Moving the data itself is left to a bus engine that consumes the array requests.

Top module: `dma3d_seq`

## Requirements
- R1: In array-synchronized mode (options bit 2 = 0), each accepted event issues exactly one request. The request appears in the cycle after the event, at the current source and destination addresses, with a length equal to the array byte count. When the frame is not ending, the addresses then advance by their own signed array strides.
- R2: In array-synchronized mode, the event that consumes the last array of a frame has three effects. The next addresses become that array's addresses plus the signed frame strides. The frame count drops by one. The array count reloads from the reload field.
- R3: In frame-synchronized mode (options bit 2 = 1), each accepted event issues the whole frame on consecutive cycles. Array k of the frame sits at the frame start plus k times the array stride. The next frame start is the previous frame start plus the frame stride. The reload field has no effect.
- R4: An event that does not finish the descriptor pulses mid_o for one cycle, in the cycle after its last request. In that same cycle, mid_irq_o equals options bit 21 and mid_chain_o equals options bit 23.
- R5: The event that completes the last frame pulses fin_o for one cycle, in the cycle after its last request. In that cycle code_o carries options bits 17:12, fin_irq_o equals options bit 20 and fin_chain_o equals options bit 22. mid_o and fin_o are never high together.
- R6: On final completion, a link field of 16'hFFFF makes the block idle. Any other value activates the stored descriptor whose index is the link's low bits, and that descriptor accepts an event in the very next cycle.
- R7: With options bit 3 (static) set, no address or count is updated. Every event completes the descriptor, and no link is followed: the same descriptor serves the next event.
- R8: An activated descriptor with a zero array byte count, array count or frame count issues no request. It pulses fin_o in the second cycle after activation and then follows its link. A static null descriptor goes idle instead.
- R9: An event that arrives while the block is idle, or while requests are being issued, or during a null completion, is dropped. It pulses miss_o in the following cycle.
- R10: After reset the block is idle, with req_valid_o, mid_o, fin_o and miss_o low.
- R11: ld_en_i writes ld_set_i into descriptor slot ld_idx_i. With ld_start_i also high, that descriptor becomes active at once, overriding any activity in progress. The descriptor packs, from its most significant field down: options[32], source[32], destination[32], array bytes[16], arrays per frame[16], frames[16], source array stride[16], destination array stride[16], source frame stride[16], destination frame stride[16], link[16], array-count reload[16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Write a descriptor into the store |
| ld_start_i | input | 1 | Also make the written descriptor active |
| ld_idx_i | input | IDXW (2) | Store slot written |
| ld_set_i | input | 240 | Descriptor contents |
| evt_i | input | 1 | Synchronization event |
| req_valid_o | output | 1 | Array request valid |
| req_src_o | output | 32 | Array source address |
| req_dst_o | output | 32 | Array destination address |
| req_len_o | output | 16 | Array byte length |
| mid_o | output | 1 | Intermediate completion pulse |
| fin_o | output | 1 | Final completion pulse |
| code_o | output | 6 | Completion code of last final completion |
| mid_irq_o | output | 1 | Intermediate interrupt request |
| fin_irq_o | output | 1 | Final interrupt request |
| mid_chain_o | output | 1 | Intermediate chaining request |
| fin_chain_o | output | 1 | Final chaining request |
| miss_o | output | 1 | Dropped-event pulse |

## Verification
The bench builds the block with its default store of four descriptor slots. That is enough for an array-synchronized descriptor to link into a frame-synchronized one, and for separate slots to hold the null and static descriptors without overwriting the chain. The frame-synchronized descriptor has three arrays per frame and a nonzero reload value, so walking the full frame and proving the reload field is ignored are both in reach. In the first descriptor the reload value differs from the initial array count, so a second frame of a different length shows the reload taking effect. Negative frame strides show that the signed offsets are sign-extended correctly.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

    typedef struct packed {
        logic [31:0] opt;
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] acnt;
        logic [15:0] bcnt;
        logic [15:0] ccnt;
        logic [15:0] sbidx;
        logic [15:0] dbidx;
        logic [15:0] scidx;
        logic [15:0] dcidx;
        logic [15:0] link;
        logic [15:0] brld;
    } pset_t;

    localparam int PSET_W      = $bits(pset_t);
    localparam int OPT_AB      = 2;
    localparam int OPT_STATIC  = 3;
    localparam int OPT_CODE_LO = 12;
    localparam int OPT_FIN_IRQ = 20;
    localparam int OPT_MID_IRQ = 21;
    localparam int OPT_FIN_CHN = 22;
    localparam int OPT_MID_CHN = 23;
    localparam logic [15:0] LINK_END = 16'hFFFF;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READY = 2'd1,
        S_BURST = 2'd2,
        S_NULL  = 2'd3
    } seq_st_e;

    function automatic logic is_null(pset_t s);
        return (s.acnt == 16'd0) || (s.bcnt == 16'd0) || (s.ccnt == 16'd0);
    endfunction

endpackage

// File: rtl/dma3d_store.sv
module dma3d_store #(
    parameter int NSETS = 4,
    parameter int W     = 8,
    localparam int IDXW = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic            clk_i,
    input  logic            we_i,
    input  logic [IDXW-1:0] widx_i,
    input  logic [W-1:0]    wdata_i,
    input  logic [IDXW-1:0] ridx_i,
    output logic [W-1:0]    rdata_o
);
    logic [W-1:0] mem_q [NSETS];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[widx_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/dma3d_step.sv
module dma3d_step (
    input  logic [31:0] base_i,
    input  logic [31:0] cur_i,
    input  logic [15:0] bidx_i,
    input  logic [15:0] cidx_i,
    output logic [31:0] base_b_o,
    output logic [31:0] base_c_o,
    output logic [31:0] cur_b_o
);
    logic [31:0] bext, cext;

    assign bext     = {{16{bidx_i[15]}}, bidx_i};
    assign cext     = {{16{cidx_i[15]}}, cidx_i};
    assign base_b_o = base_i + bext;
    assign base_c_o = base_i + cext;
    assign cur_b_o  = cur_i + bext;
endmodule

// File: rtl/dma3d_seq.sv
module dma3d_seq
    import dma3d_pkg::*;
#(
    parameter int NSETS = 4,
    localparam int IDXW = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ld_en_i,
    input  logic                  ld_start_i,
    input  logic [IDXW-1:0]       ld_idx_i,
    input  logic [PSET_W-1:0]     ld_set_i,
    input  logic                  evt_i,
    output logic                  req_valid_o,
    output logic [31:0]           req_src_o,
    output logic [31:0]           req_dst_o,
    output logic [15:0]           req_len_o,
    output logic                  mid_o,
    output logic                  fin_o,
    output logic [5:0]            code_o,
    output logic                  mid_irq_o,
    output logic                  fin_irq_o,
    output logic                  mid_chain_o,
    output logic                  fin_chain_o,
    output logic                  miss_o
);
    typedef struct packed {
        seq_st_e     st;
        pset_t       w;
        logic [31:0] cs;
        logic [31:0] cd;
        logic [15:0] k;
        logic        mid, fin, miss, mi, fi, mc, fc;
        logic [5:0]  code;
    } regs_t;

    regs_t r_d, r_q;
    pset_t tbl_set, ld_set;
    logic [PSET_W-1:0] tbl_raw;
    logic [31:0] base_a [2];
    logic [31:0] cur_a  [2];
    logic [15:0] bidx_a [2];
    logic [15:0] cidx_a [2];
    logic [31:0] base_b [2];
    logic [31:0] base_c [2];
    logic [31:0] cur_b  [2];
    logic is_ab, stat, last, do_fin, do_mid, follow;

    assign ld_set = pset_t'(ld_set_i);
    assign tbl_set = pset_t'(tbl_raw);

    dma3d_store #(.NSETS(NSETS), .W(PSET_W)) u_store (
        .clk_i  (clk_i),
        .we_i   (ld_en_i),
        .widx_i (ld_idx_i),
        .wdata_i(ld_set_i),
        .ridx_i (r_q.w.link[IDXW-1:0]),
        .rdata_o(tbl_raw)
    );

    always_comb begin
        base_a[0] = r_q.w.src;   base_a[1] = r_q.w.dst;
        cur_a[0]  = r_q.cs;      cur_a[1]  = r_q.cd;
        bidx_a[0] = r_q.w.sbidx; bidx_a[1] = r_q.w.dbidx;
        cidx_a[0] = r_q.w.scidx; cidx_a[1] = r_q.w.dcidx;
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        dma3d_step u_step (
            .base_i  (base_a[s]),
            .cur_i   (cur_a[s]),
            .bidx_i  (bidx_a[s]),
            .cidx_i  (cidx_a[s]),
            .base_b_o(base_b[s]),
            .base_c_o(base_c[s]),
            .cur_b_o (cur_b[s])
        );
    end

    assign is_ab = r_q.w.opt[OPT_AB];
    assign stat  = r_q.w.opt[OPT_STATIC];
    assign last  = !is_ab || (r_q.k == r_q.w.bcnt - 16'd1);

    always_comb begin
        r_d      = r_q;
        r_d.mid  = 1'b0; r_d.fin = 1'b0; r_d.miss = 1'b0;
        r_d.mi   = 1'b0; r_d.fi  = 1'b0; r_d.mc   = 1'b0; r_d.fc = 1'b0;
        do_fin   = 1'b0;
        do_mid   = 1'b0;
        follow   = 1'b0;
        case (r_q.st)
            S_IDLE: r_d.miss = evt_i;
            S_READY: begin
                if (evt_i) begin
                    r_d.st = S_BURST;
                    r_d.cs = r_q.w.src;
                    r_d.cd = r_q.w.dst;
                    r_d.k  = '0;
                end
            end
            S_BURST: begin
                r_d.miss = evt_i;
                if (!last) begin
                    r_d.k  = r_q.k + 16'd1;
                    r_d.cs = cur_b[0];
                    r_d.cd = cur_b[1];
                end else if (stat) begin
                    do_fin = 1'b1;
                    r_d.st = S_READY;
                end else begin
                    if (is_ab || r_q.w.bcnt == 16'd1) begin
                        r_d.w.ccnt = r_q.w.ccnt - 16'd1;
                        r_d.w.src  = base_c[0];
                        r_d.w.dst  = base_c[1];
                        if (!is_ab) r_d.w.bcnt = r_q.w.brld;
                    end else begin
                        r_d.w.bcnt = r_q.w.bcnt - 16'd1;
                        r_d.w.src  = base_b[0];
                        r_d.w.dst  = base_b[1];
                    end
                    if ((is_ab || r_q.w.bcnt == 16'd1) && r_q.w.ccnt == 16'd1) begin
                        do_fin = 1'b1;
                        follow = 1'b1;
                    end else begin
                        do_mid = 1'b1;
                        r_d.st = S_READY;
                    end
                end
            end
            default: begin
                r_d.miss = evt_i;
                do_fin   = 1'b1;
                follow   = !stat;
                if (stat) r_d.st = S_IDLE;
            end
        endcase
        if (do_fin) begin
            r_d.fin  = 1'b1;
            r_d.code = r_q.w.opt[OPT_CODE_LO +: 6];
            r_d.fi   = r_q.w.opt[OPT_FIN_IRQ];
            r_d.fc   = r_q.w.opt[OPT_FIN_CHN];
        end
        if (do_mid) begin
            r_d.mid = 1'b1;
            r_d.mi  = r_q.w.opt[OPT_MID_IRQ];
            r_d.mc  = r_q.w.opt[OPT_MID_CHN];
        end
        if (follow) begin
            if (r_q.w.link == LINK_END) begin
                r_d.st = S_IDLE;
            end else begin
                r_d.w  = tbl_set;
                r_d.st = is_null(tbl_set) ? S_NULL : S_READY;
            end
        end
        if (ld_en_i && ld_start_i) begin
            r_d.w  = ld_set;
            r_d.st = is_null(ld_set) ? S_NULL : S_READY;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign req_valid_o = (r_q.st == S_BURST);
    assign req_src_o   = r_q.cs;
    assign req_dst_o   = r_q.cd;
    assign req_len_o   = r_q.w.acnt;
    assign mid_o       = r_q.mid;
    assign fin_o       = r_q.fin;
    assign code_o      = r_q.code;
    assign mid_irq_o   = r_q.mi;
    assign fin_irq_o   = r_q.fi;
    assign mid_chain_o = r_q.mc;
    assign fin_chain_o = r_q.fc;
    assign miss_o      = r_q.miss;

    logic unused_bits;
    assign unused_bits = ^{r_q.w.opt[31:24], r_q.w.opt[19:18], r_q.w.opt[11:4], r_q.w.opt[1:0]};

    AST_REQ_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |-> req_len_o != 16'd0);                                    // R8
    AST_MISS_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i && req_valid_o) |=> miss_o);                                     // R9
    AST_FIN_MID_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(fin_o && mid_o));                                                     // R5
    AST_FIN_FLAGS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fin_irq_o || fin_chain_o) |-> fin_o);                                  // R5
    AST_MID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mid_o |-> $past(req_valid_o));                                          // R4
    AST_READY_HOLDS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == S_READY && !evt_i && !ld_en_i) |=> $stable(r_q.w));          // R7
endmodule

// File: tb/tb_dma3d_seq.sv
`timescale 1ns/1ps
module tb_dma3d_seq;
    import dma3d_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_en = 1'b0, ld_start = 1'b0, evt = 1'b0;
    logic [1:0] ld_idx = '0;
    pset_t ld_set = '0;
    logic req_valid, mid, fin, mid_irq, fin_irq, mid_chain, fin_chain, miss;
    logic [31:0] req_src, req_dst;
    logic [15:0] req_len;
    logic [5:0] code;
    int nchk = 0, nfail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma3d_seq #(.NSETS(4)) dut (
        .clk_i(clk), .rst_ni(rst_n), .ld_en_i(ld_en), .ld_start_i(ld_start),
        .ld_idx_i(ld_idx), .ld_set_i(ld_set), .evt_i(evt),
        .req_valid_o(req_valid), .req_src_o(req_src), .req_dst_o(req_dst),
        .req_len_o(req_len), .mid_o(mid), .fin_o(fin), .code_o(code),
        .mid_irq_o(mid_irq), .fin_irq_o(fin_irq), .mid_chain_o(mid_chain),
        .fin_chain_o(fin_chain), .miss_o(miss)
    );

    typedef struct packed {
        logic [31:0] s;
        logic [31:0] d;
        logic [15:0] len;
        logic first, last, mid, fin, mirq, firq;
        logic [5:0] code;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{32'h1000, 32'h2000, 16'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 6'h05},
        '{32'h1010, 32'h2020, 16'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 6'h05},
        '{32'h1110, 32'h1FE0, 16'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 6'h05},
        '{32'h1120, 32'h2000, 16'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 6'h05},
        '{32'h1130, 32'h2020, 16'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6'h05},
        '{32'h4000, 32'h5000, 16'd8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h2A},
        '{32'h4010, 32'h5004, 16'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h2A},
        '{32'h4020, 32'h5008, 16'd8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'h2A},
        '{32'h4200, 32'h5040, 16'd8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h2A},
        '{32'h4210, 32'h5044, 16'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h2A},
        '{32'h4220, 32'h5048, 16'd8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'h2A}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic pset_t mk(input logic [31:0] opt, src, dst, input logic [15:0] a, b, c,
                                 sb, db, sc, dc, lnk, rld);
        pset_t p;
        p.opt = opt; p.src = src; p.dst = dst; p.acnt = a; p.bcnt = b; p.ccnt = c;
        p.sbidx = sb; p.dbidx = db; p.scidx = sc; p.dcidx = dc; p.link = lnk; p.brld = rld;
        return p;
    endfunction

    task automatic load(input logic [1:0] idx, input pset_t p, input logic start);
        ld_en = 1'b1; ld_start = start; ld_idx = idx; ld_set = p;
        @(negedge clk);
        ld_en = 1'b0; ld_start = 1'b0;
    endtask

    task automatic pulse_evt();
        evt = 1'b1;
        @(negedge clk);
        evt = 1'b0;
    endtask

    initial begin
        #(4 * 5000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!req_valid && !mid && !fin && !miss, "R10", {req_valid, mid, fin, miss}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid && !fin, "R10", {req_valid, fin}, 0);

        // R11: descriptor store and activation
        load(2'd1, mk(32'h0050_0000 | (32'h2A << 12) | 32'h4, 32'h4000, 32'h5000,
                      16'd8, 16'd3, 16'd2, 16'h10, 16'h4, 16'h200, 16'h40, 16'hFFFF, 16'd5), 1'b0);
        load(2'd0, mk(32'h00A0_0000 | (32'h05 << 12), 32'h1000, 32'h2000,
                      16'd4, 16'd2, 16'd2, 16'h10, 16'h20, 16'h100, 16'hFFC0, 16'd1, 16'd3), 1'b1);

        // Vector walk: R1 R2 (array mode), R3 (frame mode), R4 R5, R6 link
        for (int i = 0; i < 11; i++) begin
            if (VEC[i].first) pulse_evt();
            chk(req_valid && req_src == VEC[i].s && req_dst == VEC[i].d && req_len == VEC[i].len,
                i < 5 ? "R1/R2 request" : "R3 request",
                {req_valid, req_src, req_dst[15:0]}, {1'b1, VEC[i].s, VEC[i].d[15:0]});
            @(negedge clk);
            if (VEC[i].last) begin
                chk(!req_valid && mid == VEC[i].mid && fin == VEC[i].fin,
                    "R4/R5 completion", {req_valid, mid, fin}, {1'b0, VEC[i].mid, VEC[i].fin});
                chk(mid_irq == VEC[i].mirq && mid_chain == VEC[i].mirq &&
                    fin_irq == VEC[i].firq && fin_chain == VEC[i].firq,
                    "R4/R5 flags", {mid_irq, mid_chain, fin_irq, fin_chain},
                    {VEC[i].mirq, VEC[i].mirq, VEC[i].firq, VEC[i].firq});
                if (VEC[i].fin) chk(code == VEC[i].code, "R5 code", code, VEC[i].code);
            end
        end

        // R6: end-of-chain link leaves block idle; R9: event while idle is missed
        pulse_evt();
        chk(miss && !req_valid, "R6/R9 idle miss", {miss, req_valid}, 2'b10);
        @(negedge clk);
        chk(!miss, "R9 miss is a pulse", miss, 0);

        // R8: null descriptor
        load(2'd2, mk(32'h11 << 12, 32'hA000, 32'hB000, 16'd4, 16'd0, 16'd1,
                      16'h0, 16'h0, 16'h0, 16'h0, 16'hFFFF, 16'd0), 1'b1);
        chk(!req_valid && !fin, "R8 null first cycle", {req_valid, fin}, 0);
        @(negedge clk);
        chk(!req_valid && fin && code == 6'h11, "R8 null completion", {req_valid, fin, code}, {2'b01, 6'h11});
        @(negedge clk);
        chk(!req_valid && !fin, "R8 null no request", {req_valid, fin}, 0);

        // R7: static descriptor, linking to slot 0 must not happen
        load(2'd3, mk(32'h0010_0008 | (32'h03 << 12), 32'h7000, 32'h8000, 16'd2, 16'd1, 16'd1,
                      16'h10, 16'h10, 16'h10, 16'h10, 16'd0, 16'd0), 1'b1);
        for (int e = 0; e < 2; e++) begin
            pulse_evt();
            chk(req_valid && req_src == 32'h7000 && req_dst == 32'h8000, "R7 static address",
                {req_valid, req_src}, {1'b1, 32'h7000});
            @(negedge clk);
            chk(fin && fin_irq && !mid && code == 6'h03, "R7 static completion",
                {fin, fin_irq, mid, code}, {3'b110, 6'h03});
        end

        // R9: event during a frame burst is missed; R3 burst continues
        load(2'd3, mk(32'h0000_000C, 32'h9000, 32'h9800, 16'd1, 16'd3, 16'd1,
                      16'h10, 16'h1, 16'h0, 16'h0, 16'hFFFF, 16'd0), 1'b1);
        pulse_evt();
        chk(req_valid && req_src == 32'h9000, "R3 burst start", req_src, 32'h9000);
        pulse_evt();
        chk(miss && req_valid && req_src == 32'h9010 && req_dst == 32'h9801, "R9 busy miss",
            {miss, req_src}, {1'b1, 32'h9010});
        @(negedge clk);
        chk(req_valid && req_src == 32'h9020 && !miss, "R3 burst end", req_src, 32'h9020);
        @(negedge clk);
        chk(fin && !req_valid, "R7 static frame completion", {fin, req_valid}, 2'b10);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule